// File: doc/BRIEF.md
# Two-Half Sector Hamming Parity Generator

This block sits beside the byte data path of a flash sector buffer and builds Hamming parity while a sector streams past. A sector is treated as two independent halves. Each half keeps its own 22-bit parity word, made of 16 line-parity bits and 6 column-parity bits. With the default parameters a half is 256 bytes and the sector is 512 bytes. No byte is ever stored; only the parity state is kept.

Software steers the block with 8-bit mode commands. One command clears the parity and the byte counter. A second starts accumulation. A third turns data-register reads into result reads. A fourth returns the block to plain data mode. In result mode the six parity bytes come out as three 16-bit words in a fixed interleaved order. Each read strobe steps to the next word. The customary sequence is: clear, one dummy data read, start accumulation, stream the sector, enter result mode, make three reads, return to data mode.

Top module: `hamm_sector_ecc`

## Requirements
- R1: After reset the block is in data mode, `rd_word` is 0x0000, the byte counter is zero and all parity bits are zero.
- R2: A mode write of 0xF4 clears both halves' parity and the byte counter, leaves accumulation off and sets the read pointer to the first word. A byte presented in the same cycle is discarded.
- R3: A mode write of 0xB4 enables accumulation. A byte strobed while accumulation is off has no effect on the result.
- R4: Bytes with index 0..255 since the last clear update the first half, and indices 256..511 update the second half. Any byte after the 512th is ignored until the next 0xF4.
- R5: For each half, let p be the XOR of the 8 bits of a byte at in-half index i. For every k in 0..7, p toggles LP(2k+1) when bit k of i is 1, and toggles LP(2k) when bit k of i is 0.
- R6: For m in 0..2, CP(2m+1) is the XOR over all bytes of the data bits whose position has bit m set, and CP(2m) covers the positions with bit m clear. The column byte is {CP5..CP0, 1, 1}, so its two lowest bits always read 1.
- R7: A mode write of 0xD4 enters result mode and selects the first word. A byte strobed in that same cycle while accumulating is still counted.
- R8: In result mode the words are read in this order. First word: {first half LP15..8, first half LP7..0}. Second word: {second half LP7..0, first half column byte}. Third word: {second half column byte, second half LP15..8}. Each `data_rd` steps to the next word, the third wraps back to the first, and a read in a cycle with a mode write does not step.
- R9: Outside result mode `rd_word` is 0x0000 and `data_rd` has no effect, so the dummy read after a clear is harmless.
- R10: A mode write of 0x94 returns the block to data mode. Accumulation stops and `rd_word` reads 0x0000.
- R11: Mode writes of any other value leave the mode, the counter and the parity unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode command strobe |
| mode_cmd | input | 8 | Mode command value |
| data_wr | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte passing through the data path |
| data_rd | input | 1 | Data register read strobe |
| rd_word | output | 16 | Result word in result mode, zero otherwise |

## Verification
A mode command and a data byte can arrive in the same cycle. When the command is a clear, the byte must be lost. When the command is entry to result mode, the byte still counts under the accumulating mode. The bench provokes both cases by raising `mode_wr` and `data_wr` on one edge. It judges them against parity computed arithmetically over a sector image in which that byte is either left out or written in at its own index. A read strobe that coincides with a mode write is covered by the same reasoning: it must not advance the word pointer.

// File: rtl/hamm_ecc_pkg.sv
package hamm_ecc_pkg;
    localparam logic [7:0] CMD_CLEAR  = 8'hF4;
    localparam logic [7:0] CMD_ACCUM  = 8'hB4;
    localparam logic [7:0] CMD_RESULT = 8'hD4;
    localparam logic [7:0] CMD_DATA   = 8'h94;

    typedef enum logic [1:0] {
        MODE_DATA   = 2'd0,
        MODE_ACCUM  = 2'd1,
        MODE_RESULT = 2'd2
    } ecc_mode_e;
endpackage

// File: rtl/hamm_half_acc.sv
module hamm_half_acc #(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         din,
    output logic [2*IDX_W-1:0] lp,
    output logic [5:0]         cp
);
    localparam int LP_W = 2 * IDX_W;

    typedef struct packed {
        logic [LP_W-1:0] lp;
        logic [5:0]      cp;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        logic par;
        st_d = st_q;
        par  = ^din;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            for (int k = 0; k < IDX_W; k++) begin
                if (idx[k]) st_d.lp[2*k+1] = st_d.lp[2*k+1] ^ par;
                else        st_d.lp[2*k]   = st_d.lp[2*k]   ^ par;
            end
            for (int m = 0; m < 3; m++) begin
                for (int b = 0; b < 8; b++) begin
                    if (((b >> m) & 1) == 1) st_d.cp[2*m+1] = st_d.cp[2*m+1] ^ din[b];
                    else                     st_d.cp[2*m]   = st_d.cp[2*m]   ^ din[b];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lp = st_q.lp;
    assign cp = st_q.cp;
endmodule

// File: rtl/hamm_result_mux.sv
module hamm_result_mux #(
    parameter int LP_W = 16
) (
    input  logic            show,
    input  logic [1:0]      ptr,
    input  logic [LP_W-1:0] lp_a,
    input  logic [5:0]      cp_a,
    input  logic [LP_W-1:0] lp_b,
    input  logic [5:0]      cp_b,
    output logic [15:0]     word
);
    logic [15:0] la, lb;
    logic [7:0]  col_a, col_b;

    always_comb begin
        la    = 16'(lp_a);
        lb    = 16'(lp_b);
        col_a = {cp_a, 2'b11};
        col_b = {cp_b, 2'b11};
        word  = 16'h0000;
        if (show) begin
            case (ptr)
                2'd0:    word = la;
                2'd1:    word = {lb[7:0], col_a};
                2'd2:    word = {col_b, lb[15:8]};
                default: word = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/hamm_sector_ecc.sv
module hamm_sector_ecc #(
    parameter int HALF_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [7:0]  mode_cmd,
    input  logic        data_wr,
    input  logic [7:0]  data_byte,
    input  logic        data_rd,
    output logic [15:0] rd_word
);
    import hamm_ecc_pkg::*;

    localparam int IDX_W  = $clog2(HALF_BYTES);
    localparam int LP_W   = 2 * IDX_W;
    localparam int CNT_W  = IDX_W + 2;
    localparam int HALVES = 2;

    typedef struct packed {
        ecc_mode_e        mode;
        logic [CNT_W-1:0] count;
        logic [1:0]       ptr;
    } ctl_t;

    ctl_t st_d, st_q;
    logic clr_d;
    logic take_d;

    always_comb begin
        st_d   = st_q;
        clr_d  = 1'b0;
        if (mode_wr) begin
            case (mode_cmd)
                CMD_CLEAR: begin
                    clr_d      = 1'b1;
                    st_d.count = '0;
                    st_d.ptr   = 2'd0;
                    st_d.mode  = MODE_DATA;
                end
                CMD_ACCUM:  st_d.mode = MODE_ACCUM;
                CMD_RESULT: begin
                    st_d.mode = MODE_RESULT;
                    st_d.ptr  = 2'd0;
                end
                CMD_DATA:   st_d.mode = MODE_DATA;
                default:    ;
            endcase
        end
        take_d = data_wr && (st_q.mode == MODE_ACCUM) && !st_q.count[CNT_W-1] && !clr_d;
        if (take_d) st_d.count = st_q.count + 1'b1;
        if (data_rd && !mode_wr && st_q.mode == MODE_RESULT)
            st_d.ptr = (st_q.ptr == 2'd2) ? 2'd0 : st_q.ptr + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_DATA;
            st_q.count <= '0;
            st_q.ptr   <= 2'd0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [LP_W-1:0] lp_h [HALVES];
    logic [5:0]      cp_h [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        hamm_half_acc #(.IDX_W(IDX_W)) acc_i (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_d),
            .en   (take_d && (st_q.count[IDX_W] == h[0])),
            .idx  (st_q.count[IDX_W-1:0]),
            .din  (data_byte),
            .lp   (lp_h[h]),
            .cp   (cp_h[h])
        );
    end

    hamm_result_mux #(.LP_W(LP_W)) mux_i (
        .show(st_q.mode == MODE_RESULT),
        .ptr (st_q.ptr),
        .lp_a(lp_h[0]),
        .cp_a(cp_h[0]),
        .lp_b(lp_h[1]),
        .cp_b(cp_h[1]),
        .word(rd_word)
    );

    ecc_mode_e        mode_q;
    logic [CNT_W-1:0] count_q;
    logic [1:0]       ptr_q;
    assign mode_q  = st_q.mode;
    assign count_q = st_q.count;
    assign ptr_q   = st_q.ptr;
endmodule

// File: rtl/hamm_sector_ecc_chk.sv
module hamm_sector_ecc_chk
    import hamm_ecc_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOTAL = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [7:0]       mode_cmd,
    input logic             data_wr,
    input logic [15:0]      rd_word,
    input ecc_mode_e        mode_q,
    input logic [CNT_W-1:0] count_q,
    input logic [1:0]       ptr_q
);
    assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_RESULT) |-> (rd_word == 16'h0000));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_cmd == CMD_CLEAR) |=> (count_q == '0 && mode_q == MODE_DATA));

    assert_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q <= CNT_W'(TOTAL)));

    assert_col_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RESULT && ptr_q == 2'd1) |-> (rd_word[1:0] == 2'b11));

    assert_col_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RESULT && ptr_q == 2'd2) |-> (rd_word[9:8] == 2'b11));

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !mode_wr && mode_q != MODE_ACCUM) |=> $stable(count_q));

    assert_unknown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_cmd != CMD_CLEAR && mode_cmd != CMD_ACCUM &&
         mode_cmd != CMD_RESULT && mode_cmd != CMD_DATA && !data_wr) |=> ($stable(mode_q) && $stable(count_q)));

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q <= 2'd2));

    assert_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_cmd == CMD_RESULT) |=> (mode_q == MODE_RESULT && ptr_q == 2'd0));
endmodule

bind hamm_sector_ecc hamm_sector_ecc_chk #(.CNT_W(CNT_W), .TOTAL(2*HALF_BYTES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_wr (mode_wr),
    .mode_cmd(mode_cmd),
    .data_wr (data_wr),
    .rd_word (rd_word),
    .mode_q  (mode_q),
    .count_q (count_q),
    .ptr_q   (ptr_q)
);

// File: tb/hamm_sector_ecc_tb_top.sv
`timescale 1ns/1ps
module hamm_sector_ecc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_cmd = 8'h00;
    logic        data_wr = 1'b0;
    logic [7:0]  data_byte = 8'h00;
    logic        data_rd = 1'b0;
    logic [15:0] rd_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] img [512];

    always #2.5 clk = ~clk;

    hamm_sector_ecc dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cmd(mode_cmd),
        .data_wr(data_wr), .data_byte(data_byte), .data_rd(data_rd), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk);
        mode_wr = 1'b1; mode_cmd = c;
        @(posedge clk); #1;
        mode_wr = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        data_wr = 1'b1; data_byte = b;
        @(posedge clk); #1;
        data_wr = 1'b0;
    endtask

    task automatic cmd_and_put(input logic [7:0] c, input logic [7:0] b);
        @(negedge clk);
        mode_wr = 1'b1; mode_cmd = c; data_wr = 1'b1; data_byte = b;
        @(posedge clk); #1;
        mode_wr = 1'b0; data_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        data_rd = 1'b1;
        @(posedge clk); #1;
        data_rd = 1'b0;
    endtask

    function automatic logic [15:0] ref_lp(input int h);
        logic [15:0] r = '0;
        for (int i = 0; i < 256; i++) begin
            logic p = ^img[h*256+i];
            for (int k = 0; k < 8; k++) r[2*k + ((i >> k) & 1)] ^= p;
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_col(input int h);
        logic [5:0] c = '0;
        for (int i = 0; i < 256; i++)
            for (int b = 0; b < 8; b++)
                for (int m = 0; m < 3; m++)
                    c[2*m + ((b >> m) & 1)] ^= img[h*256+i][b];
        return {c, 2'b11};
    endfunction

    task automatic read_and_compare(input string req);
        logic [15:0] la, lb;
        logic [7:0]  ca, cb;
        la = ref_lp(0); lb = ref_lp(1); ca = ref_col(0); cb = ref_col(1);
        cmd(8'hD4);
        @(negedge clk); check({req, " R8 word0"}, rd_word, la);
        rd_pulse();
        @(negedge clk); check({req, " R8 word1"}, rd_word, {lb[7:0], ca});
        rd_pulse();
        @(negedge clk); check({req, " R8 word2"}, rd_word, {cb, lb[15:8]});
        rd_pulse();
    endtask

    task automatic stream_sector(input int n);
        cmd(8'hF4);
        rd_pulse();
        cmd(8'hB4);
        for (int i = 0; i < n; i++) put(img[i]);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 512; i++) img[i] = 8'h00;
    endtask

    initial begin
        #(5.0 * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rd_word", rd_word, 16'h0000);
        cmd(8'hD4);
        @(negedge clk); check("R1 reset parity word0", rd_word, 16'h0000);
        rd_pulse(); @(negedge clk); check("R1 reset parity word1", rd_word, 16'h0003);
        cmd(8'h94);

        // R5 R6 distinct patterns
        for (int i = 0; i < 512; i++) img[i] = 8'(i);
        stream_sector(512); read_and_compare("R5 R6 ramp");
        @(negedge clk); check("R8 wrap to first", rd_word, ref_lp(0));
        for (int i = 0; i < 512; i++) img[i] = 8'((i * 7 + 13) ^ (i >> 3));
        stream_sector(512); read_and_compare("R5 R6 mix");
        for (int i = 0; i < 512; i++) img[i] = 8'hFF;
        stream_sector(512); read_and_compare("R6 ones");
        cmd(8'h94);
        @(negedge clk); check("R10 data mode zero", rd_word, 16'h0000);
        rd_pulse(); @(negedge clk); check("R9 read ignored outside result", rd_word, 16'h0000);

        // R4 R5 R6 single-bit sweep across positions and halves
        foreach (img[j]) img[j] = 8'h00;
        for (int s = 0; s < 6; s++) begin
            for (int b = 0; b < 8; b++) begin
                int idx;
                case (s)
                    0: idx = 0; 1: idx = 1; 2: idx = 255;
                    3: idx = 256; 4: idx = 300; default: idx = 511;
                endcase
                clear_img();
                img[idx] = 8'(1 << b);
                stream_sector(512); read_and_compare("R4 R5 R6 single bit");
            end
        end

        // R4 bytes past the sector end ignored
        for (int i = 0; i < 512; i++) img[i] = 8'(i * 3);
        stream_sector(512);
        for (int i = 0; i < 8; i++) put(8'hA5 + 8'(i));
        read_and_compare("R4 overrun ignored");

        // R3 bytes outside accumulate mode ignored
        clear_img();
        cmd(8'hF4);
        for (int i = 0; i < 20; i++) put(8'h3C + 8'(i));
        read_and_compare("R3 no accumulate");

        // R2 clear in same cycle as byte discards the byte
        clear_img();
        cmd(8'hF4); cmd(8'hB4);
        for (int i = 0; i < 10; i++) put(8'h11 * 8'(i + 1));
        cmd_and_put(8'hF4, 8'hAA);
        cmd(8'hB4);
        read_and_compare("R2 clear with byte");

        // R7 result entry in same cycle as byte keeps the byte
        clear_img();
        for (int i = 0; i < 5; i++) img[i] = 8'h21 + 8'(i * 9);
        img[5] = 8'h5A;
        cmd(8'hF4); cmd(8'hB4);
        for (int i = 0; i < 5; i++) put(img[i]);
        begin
            logic [15:0] la;
            logic [7:0]  ca;
            la = ref_lp(0); ca = ref_col(0);
            cmd_and_put(8'hD4, 8'h5A);
            @(negedge clk); check("R7 byte counted word0", rd_word, la);
            rd_pulse();
            @(negedge clk); check("R7 byte counted word1", rd_word, {8'h00, ca});
            // R8 read together with mode write does not step
            @(negedge clk);
            mode_wr = 1'b1; mode_cmd = 8'h77; data_rd = 1'b1;
            @(posedge clk); #1;
            mode_wr = 1'b0; data_rd = 1'b0;
            @(negedge clk); check("R8 R11 no step on mode write", rd_word, {8'h00, ca});
        end

        // R11 unknown command during accumulation
        for (int i = 0; i < 512; i++) img[i] = 8'(i ^ 8'h5C);
        cmd(8'hF4); rd_pulse(); cmd(8'hB4);
        for (int i = 0; i < 200; i++) put(img[i]);
        cmd(8'h55);
        for (int i = 200; i < 512; i++) put(img[i]);
        read_and_compare("R11 unknown ignored");
        cmd(8'h94);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule